// File: doc/BRIEF.md
# Shared Ready-Strobe and Serial Data Pin Controller

This block drives one output pin that does two jobs in every conversion period. For part of the period the pin acts as a data-ready strobe: a short LOW pulse tells the reader that a fresh 24-bit result is waiting. For the rest of the period the same pin carries that result serially, one bit per falling edge of a reader-supplied serial clock, most significant bit first. Everything runs on the system clock. The serial clock is brought in through a synchronizer, and its falling edges are detected in the system clock domain.

A producer presents a result word with a one-cycle load strobe. The word is held until the next register-write interval and then placed in the output register, so a word that is being read out never changes partway through a read. The period has fixed intervals: register write, ready pulse, a settling HIGH, the data window, and a closing HIGH interval. The pin has a defined level in each interval whether the reader takes no bits, some bits, or more bits than the word holds.

Top module: `drdy_sout_pin`

## Requirements
- R1: The pin pattern repeats every 384 system clocks. Position 0 of the cycle is the first clock after reset is released.
- R2: At cycle positions 0–5 (register write) the pin is HIGH. At positions 6–11 it is LOW, which is the ready pulse. At positions 12–17 it is HIGH again.
- R3: `doutMode` is 1 at positions 12–359 (data-output mode) and 0 at positions 0–11 and 360–383 (ready mode).
- R4: At positions 18–359 the pin shows the stored word MSB first. After k synchronized falling edges of `sclkIn` with k < 24, it shows bit 23−k of the word.
- R5: If no falling edges arrive in the data window, the pin shows bit 23 (the MSB) for the whole window.
- R6: From the 24th falling edge in the data window onward, the pin is LOW until position 360.
- R7: At positions 360–383 the pin is HIGH, and the bit pointer is reset there and again at position 0. In the next data window the pin therefore starts at the MSB, even after a partial read or an over-read.
- R8: A word loaded with `loadStb` goes into the output register at the next position 0. A load made in the middle of a read does not change the bits that the current read delivers.
- R9: Falling edges of `sclkIn` outside positions 18–359 do not move the bit pointer.
- R10: After reset the pin is HIGH, `doutMode` is 0 and the stored word is zero, so the first data window shows 0 when no word has been loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclkIn | input | 1 | Reader serial clock, idle LOW, asynchronous to clk |
| resultIn | input | 24 | Result word from the producer |
| loadStb | input | 1 | One-cycle strobe that captures resultIn |
| pinOut | output | 1 | Shared ready-strobe and serial-data pin |
| doutMode | output | 1 | 1 in data-output mode, 0 in ready mode |

## Verification
The bench targets three read patterns: no read, partial reads of several lengths, and over-reads. It does so because each leaves a different level on the pin. A pointer that wraps instead of saturating would show stale bits after an over-read, and an off-by-one shift would show the wrong bit after a partial read. It loads a new word in the middle of a read: a design that wrote the output register at once would corrupt the bits still to come. It sends falling edges during the ready intervals and reads the next window again with no new load. A design that shifted outside the window, or failed to reset the pointer in the closing interval, would begin that window on a bit other than the MSB.

// File: rtl/drdy_pin_pkg.sv
package drdy_pin_pkg;
  localparam int WORD_W    = 24;
  localparam int CYCLE_LEN = 384;
  localparam int WRITE_LEN = 6;
  localparam int LOW_LEN   = 6;
  localparam int HIGH_LEN  = 6;
  localparam int TAIL_LEN  = 24;
  localparam int SYNC_LEN  = 2;

  typedef struct packed {
    logic writeDor;   // copy held word into output register, reset pointer
    logic reloadPtr;  // reset pointer at start of closing HIGH interval
    logic shiftEn;    // advance pointer on a serial-clock fall
  } ctrlStrobes_t;
endpackage

// File: rtl/drdy_sclk_sync.sv
module drdy_sclk_sync #(
  parameter int SYNC_LEN = drdy_pin_pkg::SYNC_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic sclkIn,
  output logic sclkFall
);
  logic [SYNC_LEN:0] chainQ;

  always_ff @(posedge clk) begin
    if (rst) chainQ <= '0;
    else     chainQ <= {chainQ[SYNC_LEN-1:0], sclkIn};
  end

  assign sclkFall = chainQ[SYNC_LEN] & ~chainQ[SYNC_LEN-1];
endmodule

// File: rtl/drdy_pin_ctrl.sv
module drdy_pin_ctrl
  import drdy_pin_pkg::*;
#(
  parameter int CYCLE_LEN = drdy_pin_pkg::CYCLE_LEN,
  parameter int WRITE_LEN = drdy_pin_pkg::WRITE_LEN,
  parameter int LOW_LEN   = drdy_pin_pkg::LOW_LEN,
  parameter int HIGH_LEN  = drdy_pin_pkg::HIGH_LEN,
  parameter int TAIL_LEN  = drdy_pin_pkg::TAIL_LEN,
  localparam int CNT_W    = $clog2(CYCLE_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclkFall,
  input  logic             shregMsb,
  output ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] cntQ,
  output logic             pinOut,
  output logic             doutMode
);
  localparam logic [CNT_W-1:0] LowStart  = CNT_W'(WRITE_LEN);
  localparam logic [CNT_W-1:0] HighStart = CNT_W'(WRITE_LEN + LOW_LEN);
  localparam logic [CNT_W-1:0] DataStart = CNT_W'(WRITE_LEN + LOW_LEN + HIGH_LEN);
  localparam logic [CNT_W-1:0] TailStart = CNT_W'(CYCLE_LEN - TAIL_LEN);
  localparam logic [CNT_W-1:0] LastPos   = CNT_W'(CYCLE_LEN - 1);

  logic inData;

  always_ff @(posedge clk) begin
    if (rst)                  cntQ <= '0;
    else if (cntQ == LastPos) cntQ <= '0;
    else                      cntQ <= cntQ + 1'b1;
  end

  assign inData = (cntQ >= DataStart) && (cntQ < TailStart);

  always_comb begin
    strb.writeDor  = (cntQ == '0);
    strb.reloadPtr = (cntQ == TailStart);
    strb.shiftEn   = sclkFall && inData;
  end

  always_comb begin
    if (cntQ < LowStart)       pinOut = 1'b1;
    else if (cntQ < HighStart) pinOut = 1'b0;
    else if (cntQ < DataStart) pinOut = 1'b1;
    else if (cntQ < TailStart) pinOut = shregMsb;
    else                       pinOut = 1'b1;
  end

  assign doutMode = (cntQ >= HighStart) && (cntQ < TailStart);
endmodule

// File: rtl/drdy_pin_datapath.sv
module drdy_pin_datapath
  import drdy_pin_pkg::*;
#(
  parameter int WORD_W = drdy_pin_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              loadStb,
  output logic [WORD_W-1:0] dorQ,
  output logic              shregMsb
);
  logic [WORD_W-1:0] holdQ;
  logic              holdValidQ;
  logic [WORD_W-1:0] shregQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ      <= '0;
      holdValidQ <= 1'b0;
      dorQ       <= '0;
      shregQ     <= '0;
    end else begin
      if (strb.writeDor) begin
        if (holdValidQ) begin
          dorQ   <= holdQ;
          shregQ <= holdQ;
        end else begin
          shregQ <= dorQ;
        end
      end else if (strb.reloadPtr) begin
        shregQ <= dorQ;
      end else if (strb.shiftEn) begin
        shregQ <= {shregQ[WORD_W-2:0], 1'b0};
      end
      if (strb.writeDor && holdValidQ) holdValidQ <= 1'b0;
      if (loadStb) begin
        holdQ      <= resultIn;
        holdValidQ <= 1'b1;
      end
    end
  end

  assign shregMsb = shregQ[WORD_W-1];
endmodule

// File: rtl/drdy_sout_pin.sv
module drdy_sout_pin
  import drdy_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkIn,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              loadStb,
  output logic              pinOut,
  output logic              doutMode
);
  localparam int CNT_W = $clog2(CYCLE_LEN);

  ctrlStrobes_t      strb;
  logic              sclkFall;
  logic              shregMsb;
  logic [CNT_W-1:0]  cntQ;
  logic [WORD_W-1:0] dorQ;

  drdy_sclk_sync #(.SYNC_LEN(SYNC_LEN)) syncU (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .sclkFall(sclkFall)
  );

  drdy_pin_ctrl #(
    .CYCLE_LEN(CYCLE_LEN), .WRITE_LEN(WRITE_LEN), .LOW_LEN(LOW_LEN),
    .HIGH_LEN(HIGH_LEN), .TAIL_LEN(TAIL_LEN)
  ) ctrlU (
    .clk(clk), .rst(rst), .sclkFall(sclkFall), .shregMsb(shregMsb),
    .strb(strb), .cntQ(cntQ), .pinOut(pinOut), .doutMode(doutMode)
  );

  drdy_pin_datapath #(.WORD_W(WORD_W)) dpU (
    .clk(clk), .rst(rst), .strb(strb), .resultIn(resultIn),
    .loadStb(loadStb), .dorQ(dorQ), .shregMsb(shregMsb)
  );
endmodule

// File: rtl/drdy_sout_pin_checker.sv
module drdy_sout_pin_checker
  import drdy_pin_pkg::*;
#(
  localparam int CNT_W = $clog2(CYCLE_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic              pinOut,
  input logic              doutMode,
  input logic              sclkFall,
  input logic [CNT_W-1:0]  cntQ,
  input logic [WORD_W-1:0] dorQ
);
  localparam logic [CNT_W-1:0] LowStart  = CNT_W'(WRITE_LEN);
  localparam logic [CNT_W-1:0] HighStart = CNT_W'(WRITE_LEN + LOW_LEN);
  localparam logic [CNT_W-1:0] DataStart = CNT_W'(WRITE_LEN + LOW_LEN + HIGH_LEN);
  localparam logic [CNT_W-1:0] TailStart = CNT_W'(CYCLE_LEN - TAIL_LEN);
  localparam logic [CNT_W-1:0] LastPos   = CNT_W'(CYCLE_LEN - 1);

  logic inData;
  assign inData = (cntQ >= DataStart) && (cntQ < TailStart);

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cntQ == LastPos) |=> (cntQ == '0));

  p_ready_low_r2: assert property (@(posedge clk) disable iff (rst)
    (cntQ >= LowStart && cntQ < HighStart) |-> !pinOut);

  p_mode_entry_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(doutMode) |-> pinOut);

  p_quiet_pin_r4: assert property (@(posedge clk) disable iff (rst)
    (inData && $past(inData) && !$past(sclkFall)) |-> $stable(pinOut));

  p_tail_high_r7: assert property (@(posedge clk) disable iff (rst)
    (cntQ >= TailStart) |-> pinOut);

  p_word_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (doutMode && $past(doutMode)) |-> $stable(dorQ));
endmodule

bind drdy_sout_pin drdy_sout_pin_checker chkU (
  .clk(clk), .rst(rst), .pinOut(pinOut), .doutMode(doutMode),
  .sclkFall(sclkFall), .cntQ(cntQ), .dorQ(dorQ)
);

// File: tb/drdy_sout_pin_test.sv
module drdy_sout_pin_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclkIn = 1'b0;
  logic [23:0] resultIn = '0;
  logic        loadStb = 1'b0;
  logic        pinOut;
  logic        doutMode;
  int          ph = 0;
  int          nRun = 0;
  int          nFail = 0;

  // word in [23:0], number of serial-clock falls in [31:24]
  localparam logic [31:0] VEC [7] = '{
    {8'd0,  24'hA5A5A5},
    {8'd1,  24'h123456},
    {8'd12, 24'hC3C3C3},
    {8'd23, 24'h800001},
    {8'd23, 24'h000001},
    {8'd24, 24'hFFFFFF},
    {8'd26, 24'h9ABCDE}
  };

  always #5 clk = ~clk;

  drdy_sout_pin uut (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .resultIn(resultIn),
    .loadStb(loadStb), .pinOut(pinOut), .doutMode(doutMode)
  );

  always @(posedge clk) begin
    if (rst) ph <= 0;
    else     ph <= (ph + 1) % 384;
  end

  task automatic check(input logic act, input logic exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b (pos %0d)", tag, act, exp, ph);
    end
  endtask

  task automatic waitPh(input int x);
    do @(negedge clk); while (ph != x);
  endtask

  task automatic doFalls(input int n);
    for (int i = 0; i < n; i++) begin
      sclkIn = 1'b1;
      repeat (4) @(negedge clk);
      sclkIn = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic loadWord(input logic [23:0] w);
    resultIn = w;
    loadStb  = 1'b1;
    @(negedge clk);
    loadStb  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [23:0] wA;
    logic [23:0] wB;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(pinOut, 1'b1, "R10 pin after reset");
    check(doutMode, 1'b0, "R10 mode after reset");
    waitPh(20);
    check(pinOut, 1'b0, "R10 empty word");

    // vector table: load, then read k bits in the next cycle
    for (int v = 0; v < 7; v++) begin
      logic [23:0] w;
      int k;
      logic exp;
      w = VEC[v][23:0];
      k = int'(VEC[v][31:24]);
      exp = (k >= 24) ? 1'b0 : w[23-k];
      waitPh(100);
      loadWord(w);
      waitPh(8);
      check(pinOut, 1'b0, "R2 ready pulse");
      check(doutMode, 1'b0, "R3 mode in pulse");
      waitPh(14);
      check(pinOut, 1'b1, "R2 settle high");
      check(doutMode, 1'b1, "R3 mode in settle");
      waitPh(20);
      check(pinOut, w[23], "R5 MSB before read");
      doFalls(k);
      check(pinOut, exp, (k >= 24) ? "R6 over-read" : "R4 partial read");
      waitPh(365);
      check(pinOut, 1'b1, "R7 closing high");
      check(doutMode, 1'b0, "R3 mode in closing");
    end

    // R7: no new load, pointer restarts at MSB of the same word
    waitPh(20);
    check(pinOut, VEC[6][23], "R7 pointer restart");

    // R8: load during a read does not disturb it
    wA = 24'h5A3C96;
    wB = 24'h2B4D6F;
    waitPh(100);
    loadWord(wA);
    waitPh(20);
    check(pinOut, wA[23], "R8 first word MSB");
    doFalls(4);
    loadWord(wB);
    check(pinOut, wA[19], "R8 after mid-read load");
    doFalls(2);
    check(pinOut, wA[17], "R8 read continues");
    waitPh(20);
    check(pinOut, wB[23], "R8 held word written");

    // R9: falls during ready intervals are ignored
    waitPh(1);
    doFalls(2);
    waitPh(20);
    check(pinOut, wB[23], "R9 early falls ignored");
    doFalls(1);
    check(pinOut, wB[22], "R9 then shifts normally");

    // R1: period held across many cycles
    waitPh(5);
    check(pinOut, 1'b1, "R1 write interval");
    waitPh(6);
    check(pinOut, 1'b0, "R1 pulse start");
    waitPh(383);
    check(pinOut, 1'b1, "R1 end of cycle");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule